// File: doc/BRIEF.md
# Cache Line Base-Delta Codec

This block packs a 32-byte cache line, made of eight 32-bit words, into a smaller form, and unpacks that form back into the full line. The compress path takes a line with a valid strobe. It classifies the line as all zero, as one word repeated, or as a set of words that each sit within a signed one-byte distance of word 0. A line that matches none of these is passed through unpacked. One clock later it presents a 2-bit encoding tag, a payload bus and the payload length in bytes.

The expand path takes a tag and a payload with its own valid strobe. One clock later it returns the rebuilt line. The eight words are produced by eight parallel adders. Each adder adds the full-width base to one sign-extended delta. A cache controller would compress lines on fill and store the tag beside the line. It would expand them on a hit. The two paths are independent and may run in the same cycle.

Top module: `bdc_line_codec`

## Requirements
- R1: The compress result (`cmp_valid_o`, `cmp_tag_o`, `cmp_payload_o`, `cmp_size_o`) appears on the clock edge after the one at which `cmp_valid_i` is high. `cmp_valid_o` is low in any cycle that does not follow an accepted line.
- R2: A line whose 256 bits are all zero gets tag 2'b01 and size 0, and its payload is all zero.
- R3: A non-zero line whose eight words are all equal gets tag 2'b10 and size 4. The word is in payload bits [31:0] and all other payload bits are zero.
- R4: For any other line, compute each difference (word i minus word 0) modulo 2^32 and read it as a signed value. If every difference lies in -128..+127, the line gets tag 2'b11 and size 12. Word 0 is in payload bits [31:0], the low byte of difference i is in bits [32+8i +: 8], and bits [255:96] are zero.
- R5: Every remaining line gets tag 2'b00 and size 32, and its payload equals the line, with word i in bits [32i +: 32].
- R6: The pattern checks apply in fixed priority: zero first, then repeated, then base-delta, then uncompressed. So an all-zero line is never tagged repeated or base-delta, and a repeated line is never tagged base-delta.
- R7: `dec_valid_o` and `dec_line_o` update on the clock edge after the one at which `dec_valid_i` is high. `dec_valid_o` is low in any other cycle.
- R8: Expansion follows the tag. Tag 2'b01 gives an all-zero line whatever the payload. Tag 2'b10 repeats payload[31:0] in all eight words. Tag 2'b00 copies the payload. Tag 2'b11 gives word i = payload[31:0] + sign-extended payload[32+8i +: 8]. Feeding any compress result back into the expand path restores the original line bit for bit.
- R9: Differences wrap modulo 2^32. A word just past 0xFFFFFFFF, relative to a base just below it, still fits the base-delta form and is rebuilt exactly.
- R10: While `rst_n` is low, `cmp_valid_o` and `dec_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid_i | input | 1 | Line to compress is present |
| cmp_line_i | input | 256 | Uncompressed line, word i in bits [32i +: 32] |
| cmp_valid_o | output | 1 | Compress result valid |
| cmp_tag_o | output | 2 | Encoding tag |
| cmp_payload_o | output | 256 | Packed payload, unused bits zero |
| cmp_size_o | output | 6 | Payload length in bytes |
| dec_valid_i | input | 1 | Packed line to expand is present |
| dec_tag_i | input | 2 | Encoding tag of the packed line |
| dec_payload_i | input | 256 | Packed payload |
| dec_valid_o | output | 1 | Expanded line valid |
| dec_line_o | output | 256 | Rebuilt line |

## Verification
The bench builds the codec with its default parameters: eight 32-bit words and one-byte deltas. At this size the whole signed delta window and the cells just outside it can be swept at every word position. Each sweep point crosses the -128 and +127 limits and the zero delta, where the line turns into the repeated pattern. Bases chosen near the 32-bit wrap show that the deltas are taken modulo 2^32. Narrow random lines and wide random lines fill in the base-delta and uncompressed classes. Every compressed result is fed back through the expand path, and the rebuilt line is compared with the original.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  typedef enum logic [1:0] {
    ENC_RAW       = 2'b00,
    ENC_ZERO      = 2'b01,
    ENC_REPEAT    = 2'b10,
    ENC_BASEDELTA = 2'b11
  } enc_e;

endpackage

// File: rtl/bdc_pattern_scan.sv
// Per-word difference against word 0 and pattern flags for the whole line.
module bdc_pattern_scan #(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter int DELTA_W = 8,
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic [LINE_W-1:0]        line_i,
  output logic                     all_zero_o,
  output logic                     all_same_o,
  output logic                     deltas_fit_o,
  output logic [WORDS*DELTA_W-1:0] deltas_o
);

  localparam int HI_W = WORD_W - DELTA_W + 1;

  logic [WORDS-1:0] word_nz;
  logic [WORDS-1:0] word_same;
  logic [WORDS-1:0] word_fit;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic [WORD_W-1:0] diff;
    logic [HI_W-1:0]   hi;
    always_comb begin
      diff         = line_i[gi*WORD_W +: WORD_W] - line_i[0 +: WORD_W];
      hi           = diff[WORD_W-1:DELTA_W-1];
      word_nz[gi]  = |line_i[gi*WORD_W +: WORD_W];
      word_same[gi] = (diff == '0);
      // a signed delta fits when its upper bits are pure sign extension
      word_fit[gi] = (&hi) | ~(|hi);
      deltas_o[gi*DELTA_W +: DELTA_W] = diff[DELTA_W-1:0];
    end
  end

  assign all_zero_o   = ~(|word_nz);
  assign all_same_o   = &word_same;
  assign deltas_fit_o = &word_fit;

endmodule

// File: rtl/bdc_pack.sv
// Priority select of the encoding and assembly of the payload bus.
module bdc_pack
  import bdc_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter int DELTA_W = 8,
  localparam int LINE_W     = WORDS * WORD_W,
  localparam int LINE_BYTES = LINE_W / 8,
  localparam int SIZE_W     = $clog2(LINE_BYTES + 1),
  localparam int BD_W       = WORD_W + WORDS * DELTA_W
) (
  input  logic [LINE_W-1:0]        line_i,
  input  logic                     all_zero_i,
  input  logic                     all_same_i,
  input  logic                     deltas_fit_i,
  input  logic [WORDS*DELTA_W-1:0] deltas_i,
  output enc_e                     tag_o,
  output logic [LINE_W-1:0]        payload_o,
  output logic [SIZE_W-1:0]        size_o
);

  localparam logic [SIZE_W-1:0] SZ_RAW    = SIZE_W'(LINE_BYTES);
  localparam logic [SIZE_W-1:0] SZ_REPEAT = SIZE_W'(WORD_W / 8);
  localparam logic [SIZE_W-1:0] SZ_BD     = SIZE_W'(BD_W / 8);

  always_comb begin
    payload_o = '0;
    if (all_zero_i) begin
      tag_o  = ENC_ZERO;
      size_o = '0;
    end else if (all_same_i) begin
      tag_o  = ENC_REPEAT;
      size_o = SZ_REPEAT;
      payload_o[WORD_W-1:0] = line_i[WORD_W-1:0];
    end else if (deltas_fit_i) begin
      tag_o  = ENC_BASEDELTA;
      size_o = SZ_BD;
      payload_o[BD_W-1:0] = {deltas_i, line_i[WORD_W-1:0]};
    end else begin
      tag_o     = ENC_RAW;
      size_o    = SZ_RAW;
      payload_o = line_i;
    end
  end

endmodule

// File: rtl/bdc_unpack.sv
// Rebuilds a line: one adder per word adds the base to a sign-extended delta.
module bdc_unpack
  import bdc_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter int DELTA_W = 8,
  localparam int LINE_W = WORDS * WORD_W
) (
  input  enc_e              tag_i,
  input  logic [LINE_W-1:0] payload_i,
  output logic [LINE_W-1:0] line_o
);

  logic [WORD_W-1:0] base;
  logic [LINE_W-1:0] bd_line;
  logic [LINE_W-1:0] rep_line;

  assign base = payload_i[WORD_W-1:0];

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_lane
    logic [DELTA_W-1:0] d;
    assign d = payload_i[WORD_W + gi*DELTA_W +: DELTA_W];
    assign bd_line[gi*WORD_W +: WORD_W] =
      base + {{(WORD_W-DELTA_W){d[DELTA_W-1]}}, d};
    assign rep_line[gi*WORD_W +: WORD_W] = base;
  end

  always_comb begin
    unique case (tag_i)
      ENC_ZERO:      line_o = '0;
      ENC_REPEAT:    line_o = rep_line;
      ENC_BASEDELTA: line_o = bd_line;
      default:       line_o = payload_i;
    endcase
  end

endmodule

// File: rtl/bdc_line_codec.sv
module bdc_line_codec
  import bdc_pkg::*;
#(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter int DELTA_W = 8,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int SIZE_W = $clog2(LINE_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid_i,
  input  logic [LINE_W-1:0] cmp_line_i,
  output logic              cmp_valid_o,
  output logic [1:0]        cmp_tag_o,
  output logic [LINE_W-1:0] cmp_payload_o,
  output logic [SIZE_W-1:0] cmp_size_o,
  input  logic              dec_valid_i,
  input  logic [1:0]        dec_tag_i,
  input  logic [LINE_W-1:0] dec_payload_i,
  output logic              dec_valid_o,
  output logic [LINE_W-1:0] dec_line_o
);

  // ---------------- compress path ----------------
  logic                     scan_zero, scan_same, scan_fit;
  logic [WORDS*DELTA_W-1:0] scan_deltas;
  enc_e                     pack_tag;
  logic [LINE_W-1:0]        pack_payload;
  logic [SIZE_W-1:0]        pack_size;

  bdc_pattern_scan #(.WORDS(WORDS), .WORD_W(WORD_W), .DELTA_W(DELTA_W)) u_scan (
    .line_i       (cmp_line_i),
    .all_zero_o   (scan_zero),
    .all_same_o   (scan_same),
    .deltas_fit_o (scan_fit),
    .deltas_o     (scan_deltas)
  );

  bdc_pack #(.WORDS(WORDS), .WORD_W(WORD_W), .DELTA_W(DELTA_W)) u_pack (
    .line_i       (cmp_line_i),
    .all_zero_i   (scan_zero),
    .all_same_i   (scan_same),
    .deltas_fit_i (scan_fit),
    .deltas_i     (scan_deltas),
    .tag_o        (pack_tag),
    .payload_o    (pack_payload),
    .size_o       (pack_size)
  );

  logic              cmp_vld_d, cmp_vld_q;
  logic [1:0]        cmp_tag_d, cmp_tag_q;
  logic [LINE_W-1:0] cmp_pay_d, cmp_pay_q;
  logic [SIZE_W-1:0] cmp_size_d, cmp_size_q;

  always_comb begin
    cmp_vld_d  = cmp_valid_i;
    cmp_tag_d  = cmp_tag_q;
    cmp_pay_d  = cmp_pay_q;
    cmp_size_d = cmp_size_q;
    if (cmp_valid_i) begin
      cmp_tag_d  = pack_tag;
      cmp_pay_d  = pack_payload;
      cmp_size_d = pack_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_vld_q  <= 1'b0;
      cmp_tag_q  <= ENC_RAW;
      cmp_pay_q  <= '0;
      cmp_size_q <= '0;
    end else begin
      cmp_vld_q <= cmp_vld_d;
      if (cmp_valid_i) begin
        cmp_tag_q  <= cmp_tag_d;
        cmp_pay_q  <= cmp_pay_d;
        cmp_size_q <= cmp_size_d;
      end
    end
  end

  assign cmp_valid_o   = cmp_vld_q;
  assign cmp_tag_o     = cmp_tag_q;
  assign cmp_payload_o = cmp_pay_q;
  assign cmp_size_o    = cmp_size_q;

  // ---------------- expand path ----------------
  logic [LINE_W-1:0] unpack_line;
  logic              dec_vld_d, dec_vld_q;
  logic [LINE_W-1:0] dec_line_d, dec_line_q;

  bdc_unpack #(.WORDS(WORDS), .WORD_W(WORD_W), .DELTA_W(DELTA_W)) u_unpack (
    .tag_i     (enc_e'(dec_tag_i)),
    .payload_i (dec_payload_i),
    .line_o    (unpack_line)
  );

  always_comb begin
    dec_vld_d  = dec_valid_i;
    dec_line_d = dec_valid_i ? unpack_line : dec_line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_vld_q  <= 1'b0;
      dec_line_q <= '0;
    end else begin
      dec_vld_q <= dec_vld_d;
      if (dec_valid_i) begin
        dec_line_q <= dec_line_d;
      end
    end
  end

  assign dec_valid_o = dec_vld_q;
  assign dec_line_o  = dec_line_q;

endmodule

// File: rtl/bdc_line_codec_chk.sv
module bdc_line_codec_chk #(
  parameter int WORDS   = 8,
  parameter int WORD_W  = 32,
  parameter int DELTA_W = 8,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int SIZE_W = $clog2(LINE_W / 8 + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_valid_i,
  input logic [LINE_W-1:0] cmp_line_i,
  input logic              cmp_valid_o,
  input logic [1:0]        cmp_tag_o,
  input logic [LINE_W-1:0] cmp_payload_o,
  input logic [SIZE_W-1:0] cmp_size_o,
  input logic              dec_valid_i,
  input logic [1:0]        dec_tag_i,
  input logic              dec_valid_o,
  input logic [LINE_W-1:0] dec_line_o
);

  always_comb begin
    if (!rst_n) begin
      AST_VALID_IN_RESET: assert (!cmp_valid_o && !dec_valid_o); // R10
    end
  end

  AST_CMP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid_i |=> cmp_valid_o); // R1

  AST_CMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid_i |=> !cmp_valid_o); // R1

  AST_ZERO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid_i |=> ((cmp_tag_o == 2'b01) == ($past(cmp_line_i) == '0))); // R6

  AST_ZERO_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_o && cmp_tag_o == 2'b01) |-> (cmp_payload_o == '0 && cmp_size_o == '0)); // R2

  AST_REPEAT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_o && cmp_tag_o == 2'b10) |-> (cmp_payload_o[LINE_W-1:WORD_W] == '0)); // R3

  AST_BD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid_i ##1 cmp_tag_o == 2'b11) |-> (cmp_payload_o[WORD_W-1:0] == $past(cmp_line_i[WORD_W-1:0]))); // R4

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid_i |=> dec_valid_o); // R7

  AST_DEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_i && dec_tag_i == 2'b01) |=> (dec_line_o == '0)); // R8

endmodule

bind bdc_line_codec bdc_line_codec_chk #(
  .WORDS(WORDS), .WORD_W(WORD_W), .DELTA_W(DELTA_W)
) u_chk (.*);

// File: tb/test_bdc_line_codec.sv
`timescale 1ns/1ps
module test_bdc_line_codec;

  logic         clk;
  logic         rst_n;
  logic         cmp_valid_i;
  logic [255:0] cmp_line_i;
  logic         cmp_valid_o;
  logic [1:0]   cmp_tag_o;
  logic [255:0] cmp_payload_o;
  logic [5:0]   cmp_size_o;
  logic         dec_valid_i;
  logic [1:0]   dec_tag_i;
  logic [255:0] dec_payload_i;
  logic         dec_valid_o;
  logic [255:0] dec_line_o;

  int n_checks = 0;
  int n_fails  = 0;

  bdc_line_codec i_bdc_line_codec (
    .clk, .rst_n, .cmp_valid_i, .cmp_line_i, .cmp_valid_o, .cmp_tag_o,
    .cmp_payload_o, .cmp_size_o, .dec_valid_i, .dec_tag_i, .dec_payload_i,
    .dec_valid_o, .dec_line_o
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Reference packing computed from the requirements.
  task automatic model(input logic [255:0] l, output logic [1:0] t,
                       output logic [5:0] s, output logic [255:0] p);
    logic [31:0] w0;
    logic [31:0] w;
    logic [31:0] df;
    bit z;
    bit same;
    bit fit;
    w0 = l[31:0];
    z = 1; same = 1; fit = 1;
    for (int i = 0; i < 8; i++) begin
      w  = l[32*i +: 32];
      df = w - w0;
      if (w != 0) z = 0;
      if (w != w0) same = 0;
      if ($signed(df) < -128 || $signed(df) > 127) fit = 0;
    end
    p = '0;
    if (z) begin
      t = 2'b01; s = 6'd0;
    end else if (same) begin
      t = 2'b10; s = 6'd4; p[31:0] = w0;
    end else if (fit) begin
      t = 2'b11; s = 6'd12; p[31:0] = w0;
      for (int i = 0; i < 8; i++) begin
        df = l[32*i +: 32] - w0;
        p[32 + 8*i +: 8] = df[7:0];
      end
    end else begin
      t = 2'b00; s = 6'd32; p = l;
    end
  endtask

  function automatic string req_of(input logic [1:0] t);
    case (t)
      2'b01:   return "R2";
      2'b10:   return "R3";
      2'b11:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic run_line(input logic [255:0] l, input string extra);
    logic [1:0]   et;
    logic [5:0]   es;
    logic [255:0] ep;
    string        r;
    model(l, et, es, ep);
    r = (extra != "") ? extra : req_of(et);
    @(negedge clk);
    cmp_valid_i = 1'b1;
    cmp_line_i  = l;
    @(negedge clk);
    cmp_valid_i = 1'b0;
    check(cmp_valid_o == 1'b1, "R1", "cmp_valid_o", 256'(cmp_valid_o), 256'(1));
    check(cmp_tag_o == et, r, "tag", 256'(cmp_tag_o), 256'(et));
    check(cmp_size_o == es, r, "size", 256'(cmp_size_o), 256'(es));
    check(cmp_payload_o == ep, r, "payload", cmp_payload_o, ep);
    dec_valid_i   = 1'b1;
    dec_tag_i     = cmp_tag_o;
    dec_payload_i = cmp_payload_o;
    @(negedge clk);
    dec_valid_i = 1'b0;
    check(cmp_valid_o == 1'b0, "R1", "cmp_valid_o idle", 256'(cmp_valid_o), 256'(0));
    check(dec_valid_o == 1'b1, "R7", "dec_valid_o", 256'(dec_valid_o), 256'(1));
    check(dec_line_o == l, "R8", "round trip", dec_line_o, l);
  endtask

  task automatic run_dec(input logic [1:0] t, input logic [255:0] p,
                         input logic [255:0] exp, input string r);
    @(negedge clk);
    dec_valid_i   = 1'b1;
    dec_tag_i     = t;
    dec_payload_i = p;
    @(negedge clk);
    dec_valid_i = 1'b0;
    check(dec_valid_o == 1'b1, "R7", "dec_valid_o", 256'(dec_valid_o), 256'(1));
    check(dec_line_o == exp, r, "expand", dec_line_o, exp);
    @(negedge clk);
    check(dec_valid_o == 1'b0, "R7", "dec_valid_o idle", 256'(dec_valid_o), 256'(0));
  endtask

  function automatic logic [255:0] splat(input logic [31:0] w);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[32*i +: 32] = w;
    return l;
  endfunction

  function automatic logic [255:0] ramp(input logic [31:0] b, input int step);
    logic [255:0] l;
    for (int i = 0; i < 8; i++) l[32*i +: 32] = b + 32'(i * step);
    return l;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [255:0] l;
    logic [255:0] p;
    logic [31:0]  b;
    rst_n = 1'b0;
    cmp_valid_i = 1'b0; cmp_line_i = '0;
    dec_valid_i = 1'b0; dec_tag_i = 2'b00; dec_payload_i = '0;
    repeat (3) @(negedge clk);
    check(cmp_valid_o == 1'b0, "R10", "cmp_valid_o in reset", 256'(cmp_valid_o), 256'(0));
    check(dec_valid_o == 1'b0, "R10", "dec_valid_o in reset", 256'(dec_valid_o), 256'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check(cmp_valid_o == 1'b0, "R1", "cmp_valid_o after reset", 256'(cmp_valid_o), 256'(0));

    // Zero line wins over every other pattern (R6, R2).
    run_line('0, "R6");
    // Repeated words (R3).
    run_line(splat(32'h0000_00C0), "R3");
    run_line(splat(32'hFFFF_FFFF), "R3");
    // Narrow values and nearby pointers (R4).
    run_line(ramp(32'h0000_00C0, 8), "R4");
    run_line(ramp(32'hC040_39C0, 8), "R4");
    run_line(ramp(32'h1000_0000, -16), "R4");
    // Wide ramp beyond the window (R5).
    run_line(ramp(32'h1000_0000, 200), "R5");

    // Delta sweep across every position and past both limits (R4, R5, R3).
    for (int pos = 1; pos < 8; pos++) begin
      for (int d = -136; d <= 135; d++) begin
        l = splat(32'h1234_5678);
        l[32*pos +: 32] = 32'h1234_5678 + 32'(d);
        run_line(l, "");
      end
    end

    // Wrap of the 32-bit difference (R9).
    run_line(ramp(32'hFFFF_FFF0, 9), "R9");
    run_line(ramp(32'h0000_0010, -9), "R9");
    run_line(ramp(32'h7FFF_FFF8, 3), "R9");
    l = splat(32'hFFFF_FF80);
    l[255:224] = 32'h0000_007F;
    run_line(l, "R9");

    // Random narrow and wide lines.
    for (int k = 0; k < 200; k++) begin
      b = $urandom;
      for (int i = 0; i < 8; i++) begin
        l[32*i +: 32] = (i == 0) ? b : b + 32'($signed(8'($urandom)));
      end
      run_line(l, "");
      for (int i = 0; i < 8; i++) l[32*i +: 32] = $urandom;
      run_line(l, "");
    end

    // Direct expansion: zero tag ignores payload, raw copies (R8).
    run_dec(2'b01, {8{32'hDEAD_BEEF}}, '0, "R8");
    p = ramp(32'hA5A5_0000, 77);
    run_dec(2'b00, p, p, "R8");
    p = '0; p[31:0] = 32'h0000_1000; p[32 +: 8] = 8'h80; p[40 +: 8] = 8'h7F;
    l = splat(32'h0000_1000);
    l[31:0] = 32'h0000_0F80; l[63:32] = 32'h0000_107F;
    run_dec(2'b11, p, l, "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule